// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a two-wire serial target that lets a bus host read and write a small byte-wide register file through indexed block transfers. The host opens a write by sending the target address, a starting index and a byte count; the given number of data bytes then land in consecutive registers. To read, the host sets the index in a write phase and then issues a repeated start with the read address. The target answers with a byte count, taken from a register the host can program, and then streams register contents from the index onward until the host refuses a byte.

SCL and SDA are oversampled by the system clock through two-stage synchronisers. START and STOP are seen as SDA edges while SCL is high. The target only pulls SDA low, through an output-enable pin, and it changes that pin only while SCL is low. The 7-bit target address is taken from a pin bus on the first clock after reset and then held. The whole register file is visible on a flat output bus.

Top module: `smbus_blk_target`

## Requirements
- R1: The target address is captured from `addr_sel_i` on the first clock after reset is released. Later changes on `addr_sel_i` have no effect.
- R2: A falling SDA while SCL is high is a START or a repeated START, and it restarts address reception. A rising SDA while SCL is high is a STOP, which releases SDA and returns the target to idle.
- R3: The first byte after a START is sent MSB first: the 7-bit address, then bit 0 as R/W, where 0 means write. On a match the target ACKs by holding SDA low through the ninth clock. On a mismatch it does not ACK and ignores all traffic until the next START.
- R4: In a write, the byte after the address is the starting index, taken modulo NREG. The next byte is the byte count. Each data byte is then stored at the current index and ACKed.
- R5: Data bytes beyond the byte count are NACKed and not stored. A count of 0 stores nothing.
- R6: In a read after the repeated START and the read address, the first byte returned is the count register (index 8, reset value 8'h08). Register bytes from the current index follow.
- R7: The index increments after every data byte, whether written or read, and wraps from NREG-1 to 0.
- R8: A NACK from the host on a read byte ends the read. SDA stays released until the next START.
- R9: Bits 7:4 of register 0 are reserved and always read 0. Register NREG-1 is read-only and reads 8'hA5. Writes to these bits are ACKed but change nothing.
- R10: After reset `sda_oe_o` is 0 and every register reads 0, except the count register (8'h08) and register NREG-1 (8'hA5).
- R11: `sda_oe_o` changes only while SCL is low.
- R12: Writing the count register changes the count byte returned by later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_sel_i | input | 7 | Target address, captured after reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| regs_o | output | NREG*8 | Register file contents, byte i at bits 8i+7:8i |

## Verification
Some behaviour is checked on every cycle. SDA may toggle only while SCL is low. Every START or STOP leaves SDA released on the next cycle. The captured address never moves once loaded. The reserved and read-only bits keep their fixed values on the register bus. Other behaviour needs the bench's bus-level scenarios: ACK versus NACK at the right bit, surplus and zero-count writes, the returned count byte and its reprogramming, index wrap in both directions, and silence after a host NACK.

// File: rtl/smbus_blk_pkg.sv
package smbus_blk_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_INDEX,
    PH_COUNT,
    PH_WDATA,
    PH_RDATA
  } phase_e;
endpackage

// File: rtl/smbus_blk_sync.sv
module smbus_blk_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign sda_s_o    = sda_ff[1];
  assign scl_rise_o = scl_ff[1] & ~scl_q;
  assign scl_fall_o = ~scl_ff[1] & scl_q;
  assign start_o    = scl_ff[1] & scl_q & sda_q & ~sda_ff[1];
  assign stop_o     = scl_ff[1] & scl_q & ~sda_q & sda_ff[1];
endmodule

// File: rtl/smbus_blk_regs.sv
module smbus_blk_regs #(
  parameter int          NREG    = 16,
  parameter int          CNT_IDX = 8,
  parameter logic [7:0]  CNT_RST = 8'h08,
  parameter logic [7:0]  ID_VAL  = 8'hA5,
  localparam int         IDX_W   = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [7:0]       wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [7:0]       rdata_o,
  output logic [7:0]       cnt_o,
  output logic [NREG*8-1:0] regs_o
);
  function automatic logic [7:0] wmask(input int i);
    if (i == 0)        return 8'h0F;
    if (i == NREG - 1) return 8'h00;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] fixed_val(input int i);
    if (i == NREG - 1) return ID_VAL;
    return 8'h00;
  endfunction

  function automatic logic [7:0] rst_val(input int i);
    if (i == CNT_IDX) return CNT_RST;
    return 8'h00;
  endfunction

  logic [7:0] mem  [NREG];
  logic [7:0] view [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_byte
    localparam logic [7:0] MASK = wmask(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem[g] <= rst_val(g) & MASK;
      else if (we_i && (waddr_i == IDX_W'(g)))
        mem[g] <= (wdata_i & MASK) | (mem[g] & ~MASK);
    end
    assign view[g] = (mem[g] & MASK) | (fixed_val(g) & ~MASK);
    assign regs_o[g*8 +: 8] = view[g];
  end

  assign rdata_o = view[raddr_i];
  assign cnt_o   = view[CNT_IDX];
endmodule

// File: rtl/smbus_blk_link.sv
module smbus_blk_link
  import smbus_blk_pkg::*;
#(
  parameter int  NREG  = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [6:0]       own_addr_i,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [7:0]       rd_data_i,
  input  logic [7:0]       cnt_val_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             we_o,
  output logic [IDX_W-1:0] waddr_o,
  output logic [7:0]       wdata_o,
  output logic             sda_oe_o
);
  phase_e           phase;
  logic [3:0]       bit_cnt;
  logic [7:0]       shreg, tx_sh, wr_left, tx_next;
  logic [IDX_W-1:0] idx;
  logic             cnt_sent;

  // first byte of a read is the count, then register data
  assign tx_next  = cnt_sent ? rd_data_i : cnt_val_i;
  assign rd_idx_o = idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx_sh    <= '0;
      wr_left  <= '0;
      idx      <= '0;
      cnt_sent <= 1'b0;
      sda_oe_o <= 1'b0;
      we_o     <= 1'b0;
      waddr_o  <= '0;
      wdata_o  <= '0;
    end else begin
      we_o <= 1'b0;
      if (start_i) begin
        phase    <= PH_ADDR;
        bit_cnt  <= '0;
        cnt_sent <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        phase    <= PH_IDLE;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise_i) begin
          if (bit_cnt < 4'd8 && phase != PH_RDATA) begin
            shreg   <= {shreg[6:0], sda_i};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (bit_cnt == 4'd9 && phase == PH_RDATA && cnt_sent && sda_i) begin
            phase <= PH_IDLE;  // host NACK
          end
        end else if (scl_fall_i) begin
          if (phase == PH_RDATA && bit_cnt != 4'd9) begin
            if (bit_cnt == 4'd8) begin
              sda_oe_o <= 1'b0;
              bit_cnt  <= 4'd9;
            end else begin
              sda_oe_o <= ~tx_sh[7];
              tx_sh    <= {tx_sh[6:0], 1'b0};
              bit_cnt  <= bit_cnt + 4'd1;
            end
          end else if (bit_cnt == 4'd9) begin
            if (phase == PH_RDATA) begin
              sda_oe_o <= ~tx_next[7];
              tx_sh    <= {tx_next[6:0], 1'b0};
              bit_cnt  <= 4'd1;
              if (cnt_sent) idx <= idx + 1'b1;
              cnt_sent <= 1'b1;
            end else begin
              sda_oe_o <= 1'b0;
              bit_cnt  <= '0;
            end
          end else if (bit_cnt == 4'd8) begin
            bit_cnt <= 4'd9;
            unique case (phase)
              PH_ADDR: begin
                if (shreg[7:1] == own_addr_i) begin
                  sda_oe_o <= 1'b1;
                  phase    <= shreg[0] ? PH_RDATA : PH_INDEX;
                end else begin
                  phase <= PH_IDLE;
                end
              end
              PH_INDEX: begin
                idx      <= shreg[IDX_W-1:0];
                sda_oe_o <= 1'b1;
                phase    <= PH_COUNT;
              end
              PH_COUNT: begin
                wr_left  <= shreg;
                sda_oe_o <= 1'b1;
                phase    <= PH_WDATA;
              end
              PH_WDATA: begin
                if (wr_left != 8'd0) begin
                  we_o     <= 1'b1;
                  waddr_o  <= idx;
                  wdata_o  <= shreg;
                  idx      <= idx + 1'b1;
                  wr_left  <= wr_left - 8'd1;
                  sda_oe_o <= 1'b1;
                end
              end
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/smbus_blk_target.sv
module smbus_blk_target #(
  parameter int         NREG    = 16,
  parameter int         CNT_IDX = 8,
  parameter logic [7:0] CNT_RST = 8'h08,
  parameter logic [7:0] ID_VAL  = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [6:0]        addr_sel_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [NREG*8-1:0] regs_o
);
  localparam int IDX_W = $clog2(NREG);

  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [6:0]       own_addr;
  logic             addr_vld;
  logic [IDX_W-1:0] rd_idx, waddr;
  logic [7:0]       rd_data, cnt_val, wdata;
  logic             we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_addr <= '0;
      addr_vld <= 1'b0;
    end else if (!addr_vld) begin
      own_addr <= addr_sel_i;
      addr_vld <= 1'b1;
    end
  end

  smbus_blk_sync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  smbus_blk_link #(.NREG(NREG)) u_link (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .own_addr_i (own_addr),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise & addr_vld),
    .scl_fall_i (scl_fall & addr_vld),
    .start_i    (start_det & addr_vld),
    .stop_i     (stop_det),
    .rd_data_i  (rd_data),
    .cnt_val_i  (cnt_val),
    .rd_idx_o   (rd_idx),
    .we_o       (we),
    .waddr_o    (waddr),
    .wdata_o    (wdata),
    .sda_oe_o   (sda_oe_o)
  );

  smbus_blk_regs #(
    .NREG(NREG), .CNT_IDX(CNT_IDX), .CNT_RST(CNT_RST), .ID_VAL(ID_VAL)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (rd_idx),
    .rdata_o (rd_data),
    .cnt_o   (cnt_val),
    .regs_o  (regs_o)
  );
endmodule

// File: rtl/smbus_blk_chk.sv
module smbus_blk_chk #(
  parameter int         NREG   = 16,
  parameter logic [7:0] ID_VAL = 8'hA5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              sda_oe_o,
  input logic [NREG*8-1:0] regs_o,
  input logic              start_det,
  input logic              stop_det,
  input logic [6:0]        own_addr,
  input logic              addr_vld
);
  assert_sda_moves_scl_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  assert_stop_releases_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);

  assert_start_releases_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe_o);

  assert_addr_held_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld |=> (addr_vld && $stable(own_addr)));

  assert_fixed_bits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs_o[7:4] == 4'h0) && (regs_o[NREG*8-1 -: 8] == ID_VAL));
endmodule

bind smbus_blk_target smbus_blk_chk #(.NREG(NREG), .ID_VAL(ID_VAL)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_i     (scl_i),
  .sda_oe_o  (sda_oe_o),
  .regs_o    (regs_o),
  .start_det (start_det),
  .stop_det  (stop_det),
  .own_addr  (own_addr),
  .addr_vld  (addr_vld)
);

// File: tb/sim_smbus_blk_target.sv
`timescale 1ns/1ps
module sim_smbus_blk_target;
  localparam int         NREG = 16;
  localparam int         Q    = 8;
  localparam logic [6:0] ADDR = 7'h52;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, h_low = 1'b0;
  logic [6:0] asel = ADDR;
  logic sda_line, sda_oe;
  logic [NREG*8-1:0] regs;
  int total = 0, bad = 0;
  bit done = 1'b0;
  bit oe_prev = 1'b0;
  int r11_bad = 0;
  bit watch_oe = 1'b0, oe_seen = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_line = !(h_low || sda_oe);

  smbus_blk_target #(.NREG(NREG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_sel_i(asel), .scl_i(scl),
    .sda_i(sda_line), .sda_oe_o(sda_oe), .regs_o(regs)
  );

  always @(posedge clk) begin
    if (rst_n && (sda_oe != oe_prev) && scl) r11_bad++;
    if (watch_oe && sda_oe) oe_seen = 1'b1;
    oe_prev = sda_oe;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic s);
    scl = 1'b0; tick(Q);
    h_low = !b; tick(Q);
    scl = 1'b1; tick(Q);
    s = sda_line; tick(Q);
  endtask

  task automatic start_c();
    scl = 1'b0; tick(Q);
    h_low = 1'b0; tick(Q);
    scl = 1'b1; tick(2*Q);
    h_low = 1'b1; tick(2*Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic stop_c();
    scl = 1'b0; tick(Q);
    h_low = 1'b1; tick(Q);
    scl = 1'b1; tick(2*Q);
    h_low = 1'b0; tick(2*Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = !s;
  endtask

  task automatic rd_byte(input logic ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      b[i] = s;
    end
    bit_io(!ack, s);
  endtask

  task automatic w_head(input logic [6:0] a, input logic [7:0] idx, output logic ok);
    logic a1, a2;
    start_c();
    wr_byte({a, 1'b0}, a1);
    wr_byte(idx, a2);
    ok = a1 && a2;
  endtask

  task automatic r_head(input logic [7:0] idx, output logic ok, output logic [7:0] cnt);
    logic a1, a2;
    w_head(ADDR, idx, a1);
    start_c();
    wr_byte({ADDR, 1'b1}, a2);
    rd_byte(1'b1, cnt);
    ok = a1 && a2;
  endtask

  function automatic logic [7:0] rb(input int i);
    return regs[i*8 +: 8];
  endfunction

  // {index, data written, value expected on read}
  localparam logic [23:0] VEC [5] = '{
    {8'h03, 8'h3C, 8'h3C},
    {8'h00, 8'hFF, 8'h0F},
    {8'h0F, 8'h00, 8'hA5},
    {8'h25, 8'h81, 8'h81},
    {8'h0A, 8'h7E, 8'h7E}
  };

  initial begin
    logic ok, a, a2, a3, a4;
    logic [7:0] c, d, d2, d3;
    logic [NREG*8-1:0] exp_rst;

    tick(5);
    rst_n = 1'b1;
    tick(2);
    asel = 7'h11;  // R1: ignored after capture
    tick(4);

    exp_rst = '0;
    exp_rst[8*8 +: 8] = 8'h08;
    exp_rst[(NREG-1)*8 +: 8] = 8'hA5;
    chk(sda_oe == 1'b0, "R10 sda_oe", sda_oe, 0);
    chk(regs == exp_rst, "R10 regs", regs[31:0], exp_rst[31:0]);

    foreach (VEC[k]) begin
      w_head(ADDR, VEC[k][23:16], ok);
      wr_byte(8'h01, a);
      wr_byte(VEC[k][15:8], a2);
      stop_c();
      chk(ok && a && a2, "R4 write acks", {ok, a, a2}, 3'b111);
      r_head(VEC[k][23:16], ok, c);
      rd_byte(1'b0, d);
      stop_c();
      chk(ok && c == 8'h08, "R6 count byte", c, 8'h08);
      chk(d == VEC[k][7:0], "R9 R4 readback", d, VEC[k][7:0]);
    end
    chk(rb(0) == 8'h0F, "R9 reserved bits", rb(0), 8'h0F);

    // R1/R3: new pin value not matched, rest ignored
    w_head(7'h11, 8'h02, ok);
    wr_byte(8'h01, a);
    wr_byte(8'hEE, a2);
    stop_c();
    chk(!ok && !a && !a2, "R3 R1 mismatch nack", {ok, a, a2}, 0);
    chk(rb(2) == 8'h00, "R3 mismatch no store", rb(2), 0);

    // R4/R5: count 3, fourth byte refused
    w_head(ADDR, 8'h04, ok);
    wr_byte(8'h03, a);
    wr_byte(8'h11, a2);
    wr_byte(8'h22, a3);
    wr_byte(8'h33, a4);
    chk(ok && a && a2 && a3 && a4, "R4 block acks", {a2, a3, a4}, 3'b111);
    wr_byte(8'h44, a);
    stop_c();
    chk(!a, "R5 surplus nack", a, 0);
    chk({rb(4), rb(5), rb(6)} == 24'h112233, "R4 block store", {rb(4), rb(5), rb(6)}, 24'h112233);
    chk(rb(7) == 8'h00, "R5 surplus not stored", rb(7), 0);

    w_head(ADDR, 8'h09, ok);
    wr_byte(8'h00, a);
    wr_byte(8'h99, a2);
    stop_c();
    chk(!a2 && rb(9) == 8'h00, "R5 zero count", {a2, rb(9)}, 0);

    // R7/R9: write wraps past read-only top register
    w_head(ADDR, 8'h0E, ok);
    wr_byte(8'h03, a);
    wr_byte(8'hE1, a2);
    wr_byte(8'h5A, a3);
    wr_byte(8'hF6, a4);
    stop_c();
    chk(a2 && a3 && a4, "R9 ro write acked", {a2, a3, a4}, 3'b111);
    chk({rb(14), rb(15), rb(0)} == 24'hE1A506, "R7 write wrap",
        {rb(14), rb(15), rb(0)}, 24'hE1A506);

    // R6: read stream
    r_head(8'h04, ok, c);
    rd_byte(1'b1, d);
    rd_byte(1'b1, d2);
    rd_byte(1'b0, d3);
    stop_c();
    chk(ok && c == 8'h08, "R6 count", c, 8'h08);
    chk({d, d2, d3} == 24'h112233, "R6 read stream", {d, d2, d3}, 24'h112233);

    // R7: read wrap
    r_head(8'h0F, ok, c);
    rd_byte(1'b1, d);
    rd_byte(1'b1, d2);
    rd_byte(1'b0, d3);
    stop_c();
    chk({d, d2, d3} == 24'hA50600, "R7 read wrap", {d, d2, d3}, 24'hA50600);

    // R12: reprogram count
    w_head(ADDR, 8'h08, ok);
    wr_byte(8'h01, a);
    wr_byte(8'h02, a2);
    stop_c();
    r_head(8'h08, ok, c);
    rd_byte(1'b0, d);
    stop_c();
    chk(c == 8'h02 && d == 8'h02, "R12 count reprogram", {c, d}, 16'h0202);

    // R8: after host NACK the target stays off the bus
    r_head(8'h04, ok, c);
    rd_byte(1'b0, d);
    oe_seen = 1'b0;
    watch_oe = 1'b1;
    rd_byte(1'b0, d2);
    watch_oe = 1'b0;
    stop_c();
    chk(d == 8'h11, "R8 last byte", d, 8'h11);
    chk(!oe_seen && d2 == 8'hFF, "R8 silent after nack", {oe_seen, d2}, 8'hFF);

    // R2: stop mid-write, then a fresh transaction
    w_head(ADDR, 8'h0C, ok);
    wr_byte(8'h02, a);
    wr_byte(8'h77, a2);
    stop_c();
    tick(4);
    chk(sda_oe == 1'b0, "R2 stop releases", sda_oe, 0);
    w_head(ADDR, 8'h0D, ok);
    stop_c();
    chk(ok && rb(12) == 8'h77 && rb(13) == 8'h00, "R2 stop ends write",
        {ok, rb(12), rb(13)}, {1'b1, 8'h77, 8'h00});

    chk(r11_bad == 0, "R11 sda moves with scl low", r11_bad, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule